// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block drives the address of a synchronous burst memory. A start address is captured when an address strobe is qualified by chip enable. From that single address the block then steps through a four-beat burst, one beat per cycle in which the advance input is low. Only the two least significant address bits move during a burst. The upper bits stay where the load put them.

Two beat orders are supported, and a static order-select input picks between them. The linear order counts the low bits upward and wraps inside the aligned group of four. The interleaved order XORs the start's low bits with the beat number. The captured address and the beat count are both registers. The output address is formed from them with no further register stage, so a load or an advance becomes visible right after the clock edge that performs it.

Top module: `burst_seq_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the captured address and the beat count clear, so `mem_addr` reads 0 after that edge.
- R2: At a rising edge where `ce_n` is low and either `ctl_strobe_n` or `cpu_strobe_n` is low, the block captures `addr_in`. After that edge, `mem_addr` equals the captured value.
- R3: When `ce_n` is high, neither strobe has any effect, and `mem_addr` keeps its value.
- R4: When no load happens and `step_n` is high at an edge, `mem_addr` does not change.
- R5: With `order_ilv` = 0 (linear), the low two bits of `mem_addr` equal (start low bits + beat count) mod 4. For example, start 2 gives 2, 3, 0, 1.
- R6: With `order_ilv` = 1 (interleaved), the low two bits equal the start low bits XOR the beat count. For example, start 1 gives 1, 0, 3, 2, and start 3 gives 3, 2, 1, 0.
- R7: Bits 16..2 of `mem_addr` stay equal to the captured start for the whole burst. Advancing never carries out of the low two bits.
- R8: A load at the same edge as an advance wins. The new address is captured and the beat count returns to 0.
- R9: Each edge with `step_n` low and no load raises the beat count by one, modulo 4. A fifth beat therefore returns to the start address, and the sequence keeps repeating.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | 17 | Start address offered for capture |
| ctl_strobe_n | input | 1 | Active-low load strobe, controller side |
| cpu_strobe_n | input | 1 | Active-low load strobe, processor side |
| ce_n | input | 1 | Active-low chip enable that qualifies both strobes |
| step_n | input | 1 | Active-low burst advance |
| order_ilv | input | 1 | Static order select: 1 interleaved, 0 linear |
| mem_addr | output | 17 | Current memory address |

## Verification
The hardest case to reach is a burst that wraps past its fourth beat while the start sits at the top of its group of four, with a load arriving in the same edge as an advance. The stimulus gets there by first loading an address whose low bits are 3 and whose next bit is 1. It then advances through the wrap, so that a carry into bit 2 would show up at the port. Next it advances mid-burst, and in the same cycle it presents a fresh load with `step_n` still low. The beat after that must restart from the new address. That restart shows whether the beat count was cleared or merely advanced.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int unsigned ADDR_W_DEF = 17;
    localparam int unsigned BEAT_W     = 2;
    localparam int unsigned BEATS      = 1 << BEAT_W;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } order_e;

    typedef struct packed {
        logic load;
        logic step;
    } seq_ctl_t;

    function automatic beat_t linear_low(input beat_t start, input beat_t cnt);
        return beat_t'(start + cnt);
    endfunction

    function automatic beat_t xor_low(input beat_t start, input beat_t cnt);
        return start ^ cnt;
    endfunction

endpackage

// File: rtl/burst_load_ctl.sv
module burst_load_ctl
    import burst_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ctl_strobe_n,
    input  logic              cpu_strobe_n,
    input  logic              ce_n,
    input  logic              step_n,
    output seq_ctl_t          ctl,
    output logic [ADDR_W-1:0] base_q
);

    logic strobe_any;

    always_comb begin
        strobe_any = !ctl_strobe_n || !cpu_strobe_n;
        ctl.load   = !ce_n && strobe_any;
        ctl.step   = !ctl.load && !step_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (ctl.load) begin
            base_q <= addr_in;
        end
    end

    // R2: a qualified strobe captures the offered address
    assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && (!ctl_strobe_n || !cpu_strobe_n)) |=> base_q == $past(addr_in));

    // R3: with chip enable high the captured address holds
    assert_ce_gate_R3: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> $stable(base_q));

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  seq_ctl_t ctl,
    output beat_t    cnt_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ctl.load) begin
            cnt_q <= '0;
        end else if (ctl.step) begin
            cnt_q <= cnt_q + beat_t'(1);
        end
    end

    // R8: a load clears the beat count even when an advance is requested
    assert_load_clears_R8: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> cnt_q == '0);

    // R9: an advance moves the count by one, modulo the burst length
    assert_step_wraps_R9: assert property (@(posedge clk) disable iff (rst)
        ctl.step |=> cnt_q == beat_t'($past(cnt_q) + 1));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_W_DEF
) (
    input  logic [ADDR_W-1:0] base,
    input  beat_t             cnt,
    input  logic              order_ilv,
    output logic [ADDR_W-1:0] addr_out
);

    localparam int unsigned UP_W = ADDR_W - BEAT_W;

    order_e mode;
    beat_t  lin_low;
    beat_t  ilv_low;
    beat_t  low_sel;

    always_comb begin
        mode    = order_e'(order_ilv);
        lin_low = linear_low(base[BEAT_W-1:0], cnt);
        ilv_low = xor_low(base[BEAT_W-1:0], cnt);
        case (mode)
            ORDER_XOR: low_sel = ilv_low;
            default:   low_sel = lin_low;
        endcase
    end

    generate
        if (UP_W > 0) begin : g_upper
            assign addr_out = {base[ADDR_W-1:BEAT_W], low_sel};
        end else begin : g_low_only
            assign addr_out = low_sel[ADDR_W-1:0];
        end
    endgenerate

    // R5 R6: beat zero always presents the start address in either order
    always_comb begin
        if (cnt == '0) begin
            assert_beat0_start_R5: assert (addr_out == base);
        end
    end

endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
    import burst_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ctl_strobe_n,
    input  logic              cpu_strobe_n,
    input  logic              ce_n,
    input  logic              step_n,
    input  logic              order_ilv,
    output logic [ADDR_W-1:0] mem_addr
);

    seq_ctl_t          ctl;
    logic [ADDR_W-1:0] base_q;
    beat_t             cnt_q;

    burst_load_ctl #(.ADDR_W(ADDR_W)) u_load (
        .clk          (clk),
        .rst          (rst),
        .addr_in      (addr_in),
        .ctl_strobe_n (ctl_strobe_n),
        .cpu_strobe_n (cpu_strobe_n),
        .ce_n         (ce_n),
        .step_n       (step_n),
        .ctl          (ctl),
        .base_q       (base_q)
    );

    burst_beat_ctr u_ctr (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .cnt_q (cnt_q)
    );

    burst_order_map #(.ADDR_W(ADDR_W)) u_map (
        .base      (base_q),
        .cnt       (cnt_q),
        .order_ilv (order_ilv),
        .addr_out  (mem_addr)
    );

    // R4: no load and no advance leaves the address unchanged
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!(!ce_n && (!ctl_strobe_n || !cpu_strobe_n)) && step_n && $stable(order_ilv))
        |=> $stable(mem_addr));

    // R7: an advance never disturbs the upper address bits
    assert_upper_fixed_R7: assert property (@(posedge clk) disable iff (rst)
        (!(!ce_n && (!ctl_strobe_n || !cpu_strobe_n)))
        |=> mem_addr[ADDR_W-1:BEAT_W] == $past(mem_addr[ADDR_W-1:BEAT_W]));

endmodule

// File: tb/burst_seq_gen_test.sv
module burst_seq_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [16:0] addr_in = '0;
    logic        ctl_strobe_n = 1'b1;
    logic        cpu_strobe_n = 1'b1;
    logic        ce_n = 1'b1;
    logic        step_n = 1'b1;
    logic        order_ilv = 1'b0;
    logic [16:0] mem_addr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    burst_seq_gen uut (
        .clk          (clk),
        .rst          (rst),
        .addr_in      (addr_in),
        .ctl_strobe_n (ctl_strobe_n),
        .cpu_strobe_n (cpu_strobe_n),
        .ce_n         (ce_n),
        .step_n       (step_n),
        .order_ilv    (order_ilv),
        .mem_addr     (mem_addr)
    );

    task automatic check(input logic [16:0] exp, input string req);
        checks++;
        if (mem_addr !== exp) begin
            errors++;
            $display("FAIL %s: mem_addr=%h expected=%h", req, mem_addr, exp);
        end
    endtask

    task automatic cyc(input logic ce, input logic ctl, input logic cpu,
                       input logic stp, input logic [16:0] a);
        ce_n = ce; ctl_strobe_n = ctl; cpu_strobe_n = cpu; step_n = stp; addr_in = a;
        @(posedge clk);
        #2;
        ce_n = 1'b1; ctl_strobe_n = 1'b1; cpu_strobe_n = 1'b1; step_n = 1'b1;
    endtask

    function automatic logic [16:0] beat_addr(input logic [16:0] s, input int k, input logic ilv);
        logic [1:0] kk;
        kk = 2'(k);
        return {s[16:2], ilv ? (s[1:0] ^ kk) : 2'(s[1:0] + kk)};
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check(17'h0, "R1 reset");
        rst = 1'b0;
    endtask

    task automatic t_load_linear();
        logic [16:0] s = 17'h12346;
        order_ilv = 1'b0;
        cyc(1'b0, 1'b0, 1'b1, 1'b1, s);
        check(s, "R2 controller strobe load");
        for (int k = 1; k < 4; k++) begin
            cyc(1'b1, 1'b1, 1'b1, 1'b0, 17'h0);
            check(beat_addr(s, k, 1'b0), "R5 linear beat");
        end
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 17'h0);
        check(s, "R9 fifth beat wraps to start");
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 17'h0);
        check(beat_addr(s, 1, 1'b0), "R9 sequence repeats");
    endtask

    task automatic t_hold();
        logic [16:0] cur = mem_addr;
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 17'h1FFFF);
        check(cur, "R4 hold with advance high");
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 17'h0AAAA);
        check(cur, "R4 hold when idle");
    endtask

    task automatic t_ce_gate();
        logic [16:0] cur = mem_addr;
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 17'h05555);
        check(cur, "R3 processor strobe without chip enable");
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 17'h0ABCD);
        check(cur, "R3 controller strobe without chip enable");
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 17'h05555);
        check(17'h05555, "R2 processor strobe load");
    endtask

    task automatic t_interleave();
        logic [16:0] s1 = 17'h00F01;
        logic [16:0] s3 = 17'h1C003;
        order_ilv = 1'b1;
        cyc(1'b0, 1'b0, 1'b1, 1'b1, s1);
        check(s1, "R6 interleaved load");
        for (int k = 1; k < 4; k++) begin
            cyc(1'b1, 1'b1, 1'b1, 1'b0, 17'h0);
            check(beat_addr(s1, k, 1'b1), "R6 interleaved start 1");
        end
        cyc(1'b0, 1'b1, 1'b0, 1'b1, s3);
        for (int k = 1; k < 4; k++) begin
            cyc(1'b1, 1'b1, 1'b1, 1'b0, 17'h0);
            check(beat_addr(s3, k, 1'b1), "R6 interleaved start 3");
        end
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 17'h0);
        check(s3, "R9 interleaved wrap");
        order_ilv = 1'b0;
    endtask

    task automatic t_upper_and_priority();
        logic [16:0] s = 17'h000FF;
        logic [16:0] n = 17'h0A5A6;
        order_ilv = 1'b0;
        cyc(1'b0, 1'b0, 1'b1, 1'b1, s);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 17'h0);
        check(17'h000FC, "R7 no carry into upper bits");
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 17'h0);
        check(17'h000FD, "R7 upper bits fixed");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, n);
        check(n, "R8 load wins over advance");
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 17'h0);
        check(beat_addr(n, 1, 1'b0), "R8 count restarted at zero");
    endtask

    initial begin
        fork
            begin
                @(negedge clk);
                t_reset();
                t_load_linear();
                t_hold();
                t_ce_gate();
                t_interleave();
                t_upper_and_priority();
            end
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule